// File: doc/BRIEF.md
# Low-Power Mode Controller

This block holds the two low-power request bits of an 8-bit microcontroller core and turns them into three registered clock-gating outputs: one for the CPU clock, one for the peripheral clock (timers, serial port, interrupt logic) and one for the oscillator. Software writes the control register while the core is running. Setting the sleep bit stops only the CPU clock. Setting the halt bit stops everything. If both bits are written together, halt wins.

The two low-power states are left in different ways. Any enabled interrupt that is pending wakes the core from sleep. The controller clears the sleep bit in hardware and turns the CPU clock back on, so the service routine is the first code to run. Halt ignores interrupts and can only be left through the asynchronous active-low reset. That reset is released synchronously inside the block and returns every enable to its running value.

The block never drives a clear towards RAM or the special registers. Their contents are kept by logic outside it.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: While reset is active, and once it is released, cpu_clk_en, per_clk_en and osc_en are all 1, ctl_q reads 0x00 and the controller is in the running state. Asserting rst_n low takes effect without waiting for a clock edge.
- R2: The control register keeps the sleep bit at position 0 and the halt bit at position 1. A write accepted while running stores both bits. All other bit positions of ctl_q always read 0.
- R3: A write in the running state with bit 1 = 0 and bit 0 = 1 enters sleep. From the clock edge that takes the write, cpu_clk_en = 0, per_clk_en = 1 and osc_en = 1.
- R4: A write in the running state with bit 1 = 1 enters halt, whatever the value of bit 0. From the clock edge that takes the write, all three enables are 0.
- R5: In sleep, an edge that samples irq_pending = 1 clears bit 0 of ctl_q and returns the controller to running. From that edge, cpu_clk_en = 1.
- R6: In halt, irq_pending has no effect: the enables and ctl_q stay unchanged.
- R7: Writes presented while the controller is in sleep or halt are ignored: ctl_q and the enables keep their values.
- R8: Halt is left only by reset. Reset brings all enables back to 1 and ctl_q to 0x00.
- R9: irq_pending has no effect in the running state. If a sleep write and irq_pending coincide, the write enters sleep. The controller leaves sleep at the next edge if irq_pending is still 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Write strobe for the control register |
| wr_data | input | 8 | Write data: bit 0 sleep, bit 1 halt |
| irq_pending | input | 1 | An enabled interrupt is pending |
| cpu_clk_en | output | 1 | CPU clock enable (registered) |
| per_clk_en | output | 1 | Peripheral clock enable (registered) |
| osc_en | output | 1 | Oscillator enable (registered) |
| ctl_q | output | 8 | Control register contents |

## Verification
A software write that requests sleep can arrive in the same cycle as a pending interrupt. This could race the entry into sleep against the wake-up. The bench drives wr_en with bit 0 set and irq_pending high together on one edge. It then expects cpu_clk_en = 0 with ctl_q = 0x01 after that edge. While irq_pending stays high, it expects cpu_clk_en = 1 with ctl_q = 0x00 after the next edge. The same coincidence is also applied in halt, where the bench expects neither the write nor the interrupt to change any output.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  typedef enum logic [1:0] {
    PM_RUN   = 2'd0,
    PM_IDLE  = 2'd1,
    PM_PDOWN = 2'd2
  } pm_state_e;
endpackage

// File: rtl/pmc_rst_sync.sv
module pmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q <= '0;
    else         chain_q <= {chain_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/pmc_ctrl_reg.sv
module pmc_ctrl_reg
  import pmc_pkg::*;
#(
  parameter int REG_W   = 8,
  parameter int IDL_POS = 0,
  parameter int PD_POS  = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_pending,
  input  pm_state_e        state_q,
  output logic             sleep_q,
  output logic             halt_q
);
  logic accept, wake, sleep_d, halt_d;

  assign accept = wr_en && (state_q == PM_RUN);
  assign wake   = irq_pending && (state_q == PM_IDLE);

  always_comb begin
    sleep_d = sleep_q;
    halt_d  = halt_q;
    if (accept) begin
      sleep_d = wr_data[IDL_POS];
      halt_d  = wr_data[PD_POS];
    end else if (wake) begin
      sleep_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sleep_q <= 1'b0;
      halt_q  <= 1'b0;
    end else begin
      sleep_q <= sleep_d;
      halt_q  <= halt_d;
    end
  end

  // R6 / R7: nothing alters the register during halt
  assert_halt_reg_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_PDOWN) |=> ($stable(sleep_q) && $stable(halt_q)));

  // R7: a write presented in sleep without a wake is dropped
  assert_idle_write_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && !irq_pending) |=> ($stable(sleep_q) && $stable(halt_q)));

  // R5: waking clears the sleep bit
  assert_wake_clears_sleep_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && irq_pending) |=> !sleep_q);
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic      wr_sleep,
  input  logic      wr_halt,
  input  logic      irq_pending,
  output pm_state_e state_q,
  output pm_state_e state_d
);
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      PM_RUN: begin
        if (wr_en) begin
          if (wr_halt)       state_d = PM_PDOWN;
          else if (wr_sleep) state_d = PM_IDLE;
        end
      end
      PM_IDLE:  if (irq_pending) state_d = PM_RUN;
      PM_PDOWN: state_d = PM_PDOWN;
      default:  state_d = PM_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= PM_RUN;
    else        state_q <= state_d;
  end

  // R8: halt is absorbing until reset
  assert_halt_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_PDOWN) |=> (state_q == PM_PDOWN));

  // R4: halt bit has priority over sleep bit
  assert_halt_priority_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && wr_en && wr_halt) |=> (state_q == PM_PDOWN));

  // R9: interrupt in running state does not move the state
  assert_run_irq_noeffect_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_RUN && !wr_en) |=> (state_q == PM_RUN));
endmodule

// File: rtl/pmc_gate.sv
module pmc_gate
  import pmc_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  pm_state_e state_d,
  input  pm_state_e state_q,
  input  logic      irq_pending,
  output logic      cpu_clk_en,
  output logic      per_clk_en,
  output logic      osc_en
);
  logic cpu_d, per_d, osc_d;

  always_comb begin
    cpu_d = 1'b1;
    per_d = 1'b1;
    osc_d = 1'b1;
    unique case (state_d)
      PM_IDLE:  cpu_d = 1'b0;
      PM_PDOWN: begin
        cpu_d = 1'b0;
        per_d = 1'b0;
        osc_d = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpu_clk_en <= 1'b1;
      per_clk_en <= 1'b1;
      osc_en     <= 1'b1;
    end else begin
      cpu_clk_en <= cpu_d;
      per_clk_en <= per_d;
      osc_en     <= osc_d;
    end
  end

  // R4: with the oscillator off, no downstream clock may be enabled
  assert_osc_off_all_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !osc_en |-> (!cpu_clk_en && !per_clk_en));

  // R3: peripherals run whenever the oscillator runs
  assert_per_follows_osc_R3: assert property (@(posedge clk) disable iff (!rst_n)
    osc_en |-> per_clk_en);

  // R5: wake from sleep restores the CPU clock at the next edge
  assert_wake_cpu_on_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == PM_IDLE && irq_pending) |=> cpu_clk_en);
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int REG_W       = 8,
  parameter int IDL_POS     = 0,
  parameter int PD_POS      = 1,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  input  logic             irq_pending,
  output logic             cpu_clk_en,
  output logic             per_clk_en,
  output logic             osc_en,
  output logic [REG_W-1:0] ctl_q
);
  logic      rst_n_s;
  logic      sleep_q, halt_q;
  pm_state_e state_q, state_d;

  pmc_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk     (clk),
    .arst_n  (rst_n),
    .rst_n_o (rst_n_s)
  );

  pmc_ctrl_reg #(.REG_W(REG_W), .IDL_POS(IDL_POS), .PD_POS(PD_POS)) u_reg (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_en       (wr_en),
    .wr_data     (wr_data),
    .irq_pending (irq_pending),
    .state_q     (state_q),
    .sleep_q     (sleep_q),
    .halt_q      (halt_q)
  );

  pmc_fsm u_fsm (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .wr_en       (wr_en),
    .wr_sleep    (wr_data[IDL_POS]),
    .wr_halt     (wr_data[PD_POS]),
    .irq_pending (irq_pending),
    .state_q     (state_q),
    .state_d     (state_d)
  );

  pmc_gate u_gate (
    .clk         (clk),
    .rst_n       (rst_n_s),
    .state_d     (state_d),
    .state_q     (state_q),
    .irq_pending (irq_pending),
    .cpu_clk_en  (cpu_clk_en),
    .per_clk_en  (per_clk_en),
    .osc_en      (osc_en)
  );

  always_comb begin
    ctl_q          = '0;
    ctl_q[IDL_POS] = sleep_q;
    ctl_q[PD_POS]  = halt_q;
  end

  // R2: only the two mode bits can ever be set
  assert_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones(ctl_q) == $countones({sleep_q, halt_q}));
endmodule

// File: tb/test_pwr_mode_ctrl.sv
module test_pwr_mode_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 13;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       wr_en;
  logic [7:0] wr_data;
  logic       irq_pending;
  logic       cpu_clk_en, per_clk_en, osc_en;
  logic [7:0] ctl_q;

  int n_run = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pwr_mode_ctrl i_pwr_mode_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .irq_pending(irq_pending), .cpu_clk_en(cpu_clk_en),
    .per_clk_en(per_clk_en), .osc_en(osc_en), .ctl_q(ctl_q)
  );

  // {wr_en, wr_data, irq, cpu, per, osc, ctl_q}
  localparam logic [20:0] VEC [NVEC] = '{
    {1'b1, 8'h00, 1'b0, 3'b111, 8'h00},  // R2 write zero, stay running
    {1'b1, 8'h01, 1'b0, 3'b011, 8'h01},  // R3 enter sleep
    {1'b0, 8'h00, 1'b0, 3'b011, 8'h01},  // R3 sleep holds
    {1'b1, 8'h00, 1'b0, 3'b011, 8'h01},  // R7 write in sleep ignored
    {1'b0, 8'h00, 1'b1, 3'b111, 8'h00},  // R5 wake
    {1'b0, 8'h00, 1'b1, 3'b111, 8'h00},  // R9 irq in running
    {1'b1, 8'h01, 1'b1, 3'b011, 8'h01},  // R9 write and irq coincide
    {1'b0, 8'h00, 1'b1, 3'b111, 8'h00},  // R9 leave at next edge
    {1'b1, 8'hFD, 1'b0, 3'b011, 8'h01},  // R2 upper bits dropped
    {1'b0, 8'h00, 1'b1, 3'b111, 8'h00},  // R5 wake again
    {1'b1, 8'h03, 1'b0, 3'b000, 8'h03},  // R4 both bits: halt
    {1'b0, 8'h00, 1'b1, 3'b000, 8'h03},  // R6 irq ignored in halt
    {1'b1, 8'h00, 1'b1, 3'b000, 8'h03}   // R7 write ignored in halt
  };

  task automatic check(string req, logic [10:0] act, logic [10:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got en=%b ctl=%h, expected en=%b ctl=%h",
               req, act[10:8], act[7:0], exp[10:8], exp[7:0]);
    end
  endtask

  function automatic logic [10:0] outs();
    return {cpu_clk_en, per_clk_en, osc_en, ctl_q};
  endfunction

  task automatic step(logic w, logic [7:0] d, logic irq);
    wr_en = w; wr_data = d; irq_pending = irq;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    wr_en = 1'b0; wr_data = 8'h00; irq_pending = 1'b0;
    rst_n = 1'b0;
    #1;
    check("R1 async reset", outs(), {3'b111, 8'h00});
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", outs(), {3'b111, 8'h00});
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_data = 8'h00; irq_pending = 1'b0;
    do_reset();

    for (int i = 0; i < NVEC; i++) begin
      step(VEC[i][20], VEC[i][19:12], VEC[i][11]);
      check($sformatf("vector %0d (R2-R9 table, see comment)", i), outs(), VEC[i][10:0]);
    end

    // R8: extra idle cycles with irq do not leave halt, reset does
    step(1'b0, 8'h00, 1'b1);
    step(1'b0, 8'h00, 1'b1);
    check("R8 halt persists", outs(), {3'b000, 8'h03});
    do_reset();
    check("R8 reset leaves halt", outs(), {3'b111, 8'h00});

    // R4: halt bit alone
    step(1'b1, 8'h02, 1'b0);
    check("R4 halt bit only", outs(), {3'b000, 8'h02});
    // R6: write plus irq in halt
    step(1'b1, 8'h01, 1'b1);
    check("R6 halt ignores irq and write", outs(), {3'b000, 8'h02});
    do_reset();

    // R5: sleep lasting several cycles, then wake
    step(1'b1, 8'h81, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    step(1'b0, 8'h00, 1'b0);
    check("R5 still sleeping", outs(), {3'b011, 8'h01});
    step(1'b0, 8'h00, 1'b1);
    check("R5 woken", outs(), {3'b111, 8'h00});

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: got timeout, expected completion");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule